// File: doc/BRIEF.md
# CAN Controller Sleep and Wake Sequencer

This block decides when a CAN protocol engine may enter its low-power state and how it comes back out. Software owns a sleep request bit and a wake-up enable bit. The engine reports whether a frame is in progress, whether it is in bus-off, the sampled receive level and a strobe at each bit sample point. From these inputs the block raises a sleep acknowledge, keeps a sticky wake-up flag, and presents a receive line that is masked while the block sleeps. It also holds the transmit line recessive and gates the queued work of the engine: moving a buffer to the foreground, aborting a transmission and starting a new one.

The controller has five states. StartUp is entered after reset and after every wake-up; it waits for 11 consecutive recessive bits and then moves to Idle. Idle moves to Sleep when the request bit is set, and to Tx/Rx Active when a frame starts. Tx/Rx Active returns to Idle when the frame ends. If a sleep request arrives during a frame, Tx/Rx Active moves to Wait-for-Idle. Wait-for-Idle returns to Idle when the frame ends, so Sleep is always entered through Idle. Sleep returns to StartUp in two cases: software clears the request, or bus activity is detected while wake-up is enabled. The frame that wakes the block is therefore lost during resynchronisation.

While the engine is in bus-off, the block counts runs of 11 recessive bits toward recovery. The count is frozen while asleep and continues from the held value after wake-up.

Top module: `can_sleep_seq`

## Requirements
- R1: Sleep is entered only from Idle. A request raised during Tx/Rx Active moves the block to Wait-for-Idle. The acknowledge then rises two clocks after `msg_active` is first sampled low: one clock to reach Idle, one clock to reach Sleep.
- R2: `sleep_ack` is high exactly while the block is in Sleep. It rises on the clock after Idle is sampled with the request bit set, and the request bit is always set while it is high.
- R3: Writing 1 (`slp_wr_en` with `slp_wr_val`=1) sets `slp_req`. Writing 0 clears it only while `sleep_ack` is high; otherwise a write of 0 has no effect. A write of 1 takes priority over every clearing cause.
- R4: Sleep is left on the clock after either of two events: a software write of 0 while acknowledged, or a wake event. A wake event is `bit_tick` with `rx_in`=0 while `wake_en`=1. On that clock `sleep_ack` falls and the block enters StartUp. A wake event also clears `slp_req`.
- R5: `wake_flag` is set by a wake event and stays set until a `wake_flag_clr` pulse. If both happen in the same clock, the set wins.
- R6: While asleep with `wake_en`=0, `rx_masked` is 1 and dominant bits neither wake the block nor set the flag. In every other case `rx_masked` equals `rx_in`.
- R7: `tx_hold_rec` is high while asleep and low otherwise.
- R8: `bus_on` is low in StartUp and Sleep and high in Idle, Tx/Rx Active and Wait-for-Idle. StartUp ends on the clock after the 11th consecutive `bit_tick` that samples `rx_masked`=1. A dominant sample restarts the run.
- R9: While asleep, `promote_go` and `abort_go` are 0. Otherwise they follow `promote_req` and `abort_req`, including in the first cycle after the acknowledge falls.
- R10: `tx_start` follows `tx_pending` only in Idle with `slp_req`=0. It is 0 in every other case.
- R11: While `bus_off`=1 and the block is awake, each run of 11 consecutive recessive bit samples adds 1 to `recov_cnt`. The count stops at 128, where `recov_done` goes high. While asleep the count and the partial run are held. `bus_off`=0 clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slp_wr_en | input | 1 | Software write strobe for the sleep request bit |
| slp_wr_val | input | 1 | Value written to the sleep request bit |
| wake_en | input | 1 | Wake-up on bus activity enable |
| wake_flag_clr | input | 1 | Write-one-to-clear pulse for the wake flag |
| rx_in | input | 1 | Sampled receive level (1 = recessive) |
| bit_tick | input | 1 | One-cycle strobe at each bit sample point |
| msg_active | input | 1 | Engine is transmitting or receiving a frame |
| bus_off | input | 1 | Engine is in bus-off |
| promote_req | input | 1 | Background buffer waits to move to foreground |
| abort_req | input | 1 | Transmit abort is pending |
| tx_pending | input | 1 | A transmit buffer is ready |
| slp_req | output | 1 | Sleep request bit |
| sleep_ack | output | 1 | Sleep acknowledge |
| wake_flag | output | 1 | Sticky wake-up flag |
| rx_masked | output | 1 | Receive line passed to the engine |
| tx_hold_rec | output | 1 | Force the transmit line recessive |
| bus_on | output | 1 | Bus participation allowed |
| promote_go | output | 1 | Foreground promotion may proceed |
| abort_go | output | 1 | Transmit abort may proceed |
| tx_start | output | 1 | New transmission may start |
| recov_cnt | output | 8 | Bus-off recovery run count |
| recov_done | output | 1 | Recovery count complete |

## Verification
A wrong state shows at the ports in the same cycle. `sleep_ack`, `bus_on` and the gated outputs are decoded from the state, so a misstep appears on the next clock. An acknowledge that rises while a frame is active, or from StartUp, breaks the two-clock Idle path of R1.

A resync counter that slips shows as `bus_on` rising one bit early or late after a dominant interruption. A bus-off count that is not frozen shows in `recov_cnt` as soon as one run of 11 bits completes during sleep.

A reference model in the bench compares every output on every clock, so a fault is reported within one cycle of its cause.

// File: rtl/canlp_pkg.sv
package canlp_pkg;
    typedef enum logic [2:0] {
        ST_STARTUP   = 3'd0,
        ST_IDLE      = 3'd1,
        ST_ACTIVE    = 3'd2,
        ST_WAIT_IDLE = 3'd3,
        ST_SLEEP     = 3'd4
    } lp_state_t;
endpackage

// File: rtl/canlp_run_cnt.sv
module canlp_run_cnt #(
    parameter int RUN_LEN = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic enable,
    input  logic tick,
    input  logic bit_in,
    output logic run_hit
);
    localparam int CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

    logic [CW-1:0] cnt_q;

    assign run_hit = enable && tick && bit_in && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (enable && tick) begin
            if (!bit_in || (cnt_q == LAST)) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R8
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(RUN_LEN));
endmodule

// File: rtl/canlp_busoff_rec.sv
module canlp_busoff_rec #(
    parameter int RUN_LEN = 11,
    parameter int SEQS    = 128,
    localparam int OW     = $clog2(SEQS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_off_i,
    input  logic          asleep_i,
    input  logic          tick_i,
    input  logic          bit_i,
    output logic [OW-1:0] occ_o,
    output logic          done_o
);
    localparam logic [OW-1:0] FULL = OW'(SEQS);

    logic [OW-1:0] occ_q;
    logic          run_en;
    logic          hit;

    assign run_en = bus_off_i && !asleep_i && (occ_q != FULL);

    canlp_run_cnt #(.RUN_LEN(RUN_LEN)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!bus_off_i),
        .enable  (run_en),
        .tick    (tick_i),
        .bit_in  (bit_i),
        .run_hit (hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else if (!bus_off_i) begin
            occ_q <= '0;
        end else if (hit) begin
            occ_q <= occ_q + 1'b1;
        end
    end

    assign occ_o  = occ_q;
    assign done_o = (occ_q == FULL);

    // R11
    hold_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep_i && bus_off_i) |=> $stable(occ_q));

    // R11
    occ_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= FULL);
endmodule

// File: rtl/canlp_fsm.sv
module canlp_fsm
    import canlp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en_i,
    input  logic      wr_val_i,
    input  logic      wake_en_i,
    input  logic      flag_clr_i,
    input  logic      rx_in_i,
    input  logic      bit_tick_i,
    input  logic      msg_active_i,
    input  logic      resync_hit_i,
    output lp_state_t state_o,
    output logic      req_o,
    output logic      ack_o,
    output logic      flag_o,
    output logic      rx_mask_o,
    output logic      tx_hold_o,
    output logic      bus_on_o
);
    lp_state_t st_q, st_d;
    logic      req_q, flag_q;
    logic      asleep, wake_evt, sw_clr_ok, leave;

    assign asleep    = (st_q == ST_SLEEP);
    assign wake_evt  = asleep && wake_en_i && bit_tick_i && !rx_in_i;
    assign sw_clr_ok = wr_en_i && !wr_val_i && asleep && req_q;
    assign leave     = wake_evt || sw_clr_ok || !req_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_STARTUP:   if (resync_hit_i) st_d = ST_IDLE;
            ST_IDLE: begin
                if (req_q)             st_d = ST_SLEEP;
                else if (msg_active_i) st_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (!msg_active_i)     st_d = ST_IDLE;
                else if (req_q)        st_d = ST_WAIT_IDLE;
            end
            ST_WAIT_IDLE: if (!msg_active_i) st_d = ST_IDLE;
            ST_SLEEP:     if (leave)         st_d = ST_STARTUP;
            default:      st_d = ST_STARTUP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_STARTUP;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (wr_en_i && wr_val_i)  req_q <= 1'b1;
            else if (sw_clr_ok)       req_q <= 1'b0;
            else if (wake_evt)        req_q <= 1'b0;

            if (wake_evt)             flag_q <= 1'b1;
            else if (flag_clr_i)      flag_q <= 1'b0;
        end
    end

    always_comb begin
        ack_o     = 1'b0;
        tx_hold_o = 1'b0;
        bus_on_o  = 1'b0;
        rx_mask_o = rx_in_i;
        unique case (st_q)
            ST_STARTUP: ;
            ST_IDLE, ST_ACTIVE, ST_WAIT_IDLE: bus_on_o = 1'b1;
            ST_SLEEP: begin
                ack_o     = 1'b1;
                tx_hold_o = 1'b1;
                if (!wake_en_i) rx_mask_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign state_o = st_q;
    assign req_o   = req_q;
    assign flag_o  = flag_q;

    // R2
    ack_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> req_q);

    // R1
    sleep_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(st_q) == ST_IDLE);

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !ack_o) |=> req_q);

    // R4
    exit_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_o) |-> (st_q == ST_STARTUP) && !bus_on_o);

    // R6
    masked_nowake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && !wake_en_i && !flag_q) |=> !flag_q);

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr_i) |=> flag_q);
endmodule

// File: rtl/can_sleep_seq.sv
module can_sleep_seq
    import canlp_pkg::*;
#(
    parameter int RUN_LEN    = 11,
    parameter int RECOV_SEQS = 128,
    localparam int OCC_W     = $clog2(RECOV_SEQS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slp_wr_en,
    input  logic             slp_wr_val,
    input  logic             wake_en,
    input  logic             wake_flag_clr,
    input  logic             rx_in,
    input  logic             bit_tick,
    input  logic             msg_active,
    input  logic             bus_off,
    input  logic             promote_req,
    input  logic             abort_req,
    input  logic             tx_pending,
    output logic             slp_req,
    output logic             sleep_ack,
    output logic             wake_flag,
    output logic             rx_masked,
    output logic             tx_hold_rec,
    output logic             bus_on,
    output logic             promote_go,
    output logic             abort_go,
    output logic             tx_start,
    output logic [OCC_W-1:0] recov_cnt,
    output logic             recov_done
);
    lp_state_t state;
    logic      resync_hit;
    logic      in_startup;

    assign in_startup = (state == ST_STARTUP);

    canlp_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (slp_wr_en),
        .wr_val_i     (slp_wr_val),
        .wake_en_i    (wake_en),
        .flag_clr_i   (wake_flag_clr),
        .rx_in_i      (rx_in),
        .bit_tick_i   (bit_tick),
        .msg_active_i (msg_active),
        .resync_hit_i (resync_hit),
        .state_o      (state),
        .req_o        (slp_req),
        .ack_o        (sleep_ack),
        .flag_o       (wake_flag),
        .rx_mask_o    (rx_masked),
        .tx_hold_o    (tx_hold_rec),
        .bus_on_o     (bus_on)
    );

    canlp_run_cnt #(.RUN_LEN(RUN_LEN)) u_resync (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!in_startup),
        .enable  (in_startup),
        .tick    (bit_tick),
        .bit_in  (rx_masked),
        .run_hit (resync_hit)
    );

    canlp_busoff_rec #(.RUN_LEN(RUN_LEN), .SEQS(RECOV_SEQS)) u_busoff (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_off_i (bus_off),
        .asleep_i  (sleep_ack),
        .tick_i    (bit_tick),
        .bit_i     (rx_masked),
        .occ_o     (recov_cnt),
        .done_o    (recov_done)
    );

    assign promote_go = promote_req && !sleep_ack;
    assign abort_go   = abort_req && !sleep_ack;
    assign tx_start   = tx_pending && (state == ST_IDLE) && !slp_req;

    // R9
    defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_ack |-> !(promote_go || abort_go || tx_start));

    // R8
    resync_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_startup && !resync_hit) |=> !bus_on);
endmodule

// File: tb/can_sleep_seq_test.sv
module can_sleep_seq_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slp_wr_en = 0, slp_wr_val = 0, wake_en = 0, wake_flag_clr = 0;
    logic rx_in = 1, bit_tick = 0, msg_active = 0, bus_off = 0;
    logic promote_req = 0, abort_req = 0, tx_pending = 0;
    logic slp_req, sleep_ack, wake_flag, rx_masked, tx_hold_rec, bus_on;
    logic promote_go, abort_go, tx_start, recov_done;
    logic [7:0] recov_cnt;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    can_sleep_seq uut (.*);

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model: 0 StartUp, 1 Idle, 2 Active, 3 WaitIdle, 4 Sleep
    int m_st, m_req, m_flag, m_rs, m_br, m_occ;
    int n_st, n_req, n_flag;
    bit m_wake, m_clr, m_rxm;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_req = 0; m_flag = 0; m_rs = 0; m_br = 0; m_occ = 0;
        end else begin
            m_rxm  = (m_st == 4 && !wake_en) ? 1'b1 : rx_in;
            m_wake = (m_st == 4) && wake_en && bit_tick && !rx_in;
            m_clr  = slp_wr_en && !slp_wr_val && (m_st == 4) && (m_req == 1);
            n_st = m_st;
            case (m_st)
                0: if (bit_tick && m_rxm && m_rs == 10) n_st = 1;
                1: if (m_req == 1) n_st = 4; else if (msg_active) n_st = 2;
                2: if (!msg_active) n_st = 1; else if (m_req == 1) n_st = 3;
                3: if (!msg_active) n_st = 1;
                default: if (m_wake || m_clr || m_req == 0) n_st = 0;
            endcase
            n_req = m_req;
            if (slp_wr_en && slp_wr_val) n_req = 1;
            else if (m_clr || m_wake)    n_req = 0;
            n_flag = m_wake ? 1 : (wake_flag_clr ? 0 : m_flag);
            if (m_st != 0) m_rs = 0;
            else if (bit_tick) m_rs = (!m_rxm || m_rs == 10) ? 0 : m_rs + 1;
            if (!bus_off) begin
                m_br = 0; m_occ = 0;
            end else if (m_st != 4 && m_occ < 128 && bit_tick) begin
                if (!m_rxm) m_br = 0;
                else if (m_br == 10) begin m_br = 0; m_occ++; end
                else m_br++;
            end
            m_st = n_st; m_req = n_req; m_flag = n_flag;
        end
    end

    // per-clock comparison
    always @(negedge clk) begin
        #1;
        if (rst_n && !finished) begin
            chk("R2 sleep_ack", sleep_ack, m_st == 4);
            chk("R3 slp_req", slp_req, m_req);
            chk("R5 wake_flag", wake_flag, m_flag);
            chk("R6 rx_masked", rx_masked, (m_st == 4 && !wake_en) ? 1 : rx_in);
            chk("R7 tx_hold_rec", tx_hold_rec, m_st == 4);
            chk("R8 bus_on", bus_on, m_st >= 1 && m_st <= 3);
            chk("R9 promote_go", promote_go, promote_req && m_st != 4);
            chk("R9 abort_go", abort_go, abort_req && m_st != 4);
            chk("R10 tx_start", tx_start, tx_pending && m_st == 1 && m_req == 0);
            chk("R11 recov_cnt", recov_cnt, m_occ);
            chk("R11 recov_done", recov_done, m_occ == 128);
        end
    end

    task automatic bits(int n, bit v);
        repeat (n) begin
            @(negedge clk); rx_in = v; bit_tick = 1;
            @(negedge clk); bit_tick = 0;
        end
    endtask

    task automatic wr_req(bit v);
        @(negedge clk); slp_wr_en = 1; slp_wr_val = v;
        @(negedge clk); slp_wr_en = 0;
    endtask

    task automatic probe();
        #2;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        probe();
        chk("R8 reset bus_on", bus_on, 0);
        chk("R2 reset ack", sleep_ack, 0);
        chk("R3 reset req", slp_req, 0);
        chk("R5 reset flag", wake_flag, 0);

        // R8: startup resync, dominant restarts the run
        bits(5, 1); bits(1, 0); bits(10, 1);
        probe(); chk("R8 ten recessive not enough", bus_on, 0);
        bits(1, 1);
        probe(); chk("R8 eleventh recessive", bus_on, 1);

        // R10: transmission start in Idle
        @(negedge clk); tx_pending = 1;
        probe(); chk("R10 tx_start in idle", tx_start, 1);
        @(negedge clk); tx_pending = 0;

        // R1/R3: sleep request during an active frame
        msg_active = 1;
        @(negedge clk);
        wr_req(1);
        wr_req(0);
        probe(); chk("R3 early clear ignored", slp_req, 1);
        repeat (3) @(negedge clk);
        probe(); chk("R1 no ack during frame", sleep_ack, 0);
        @(negedge clk); msg_active = 0;
        probe(); chk("R1 ack waits", sleep_ack, 0);
        @(negedge clk); probe(); chk("R1 idle first", sleep_ack, 0);
        @(negedge clk); probe(); chk("R1 ack after idle", sleep_ack, 1);

        // R9/R10/R7 deferral while asleep
        promote_req = 1; abort_req = 1; tx_pending = 1;
        probe();
        chk("R9 promote held", promote_go, 0);
        chk("R9 abort held", abort_go, 0);
        chk("R10 tx held", tx_start, 0);
        chk("R7 tx recessive", tx_hold_rec, 1);

        // R6: masked bus activity
        bits(3, 0);
        probe();
        chk("R6 masked rx", rx_masked, 1);
        chk("R6 still asleep", sleep_ack, 1);
        chk("R6 no flag", wake_flag, 0);

        // R4: software clear leaves sleep
        @(negedge clk); slp_wr_en = 1; slp_wr_val = 0;
        @(negedge clk); slp_wr_en = 0;
        probe();
        chk("R4 ack dropped", sleep_ack, 0);
        chk("R9 promote released", promote_go, 1);
        chk("R9 abort released", abort_go, 1);
        chk("R6 rx passes", rx_masked, 0);
        promote_req = 0; abort_req = 0; tx_pending = 0;

        // R8: resync across a frame
        bits(6, 1); bits(2, 0); bits(10, 1);
        probe(); chk("R8 frame restarts resync", bus_on, 0);
        bits(1, 1);
        probe(); chk("R8 resync done", bus_on, 1);

        // R4/R5: wake by bus activity
        wake_en = 1;
        wr_req(1);
        @(negedge clk); probe(); chk("R2 asleep again", sleep_ack, 1);
        bits(1, 0);
        probe();
        chk("R4 woken", sleep_ack, 0);
        chk("R5 flag set", wake_flag, 1);
        chk("R4 req cleared", slp_req, 0);
        @(negedge clk); wake_flag_clr = 1; rx_in = 1;
        @(negedge clk); wake_flag_clr = 0;
        probe(); chk("R5 flag cleared", wake_flag, 0);
        bits(11, 1);
        probe(); chk("R8 resync after wake", bus_on, 1);

        // R11: bus-off recovery held across sleep
        @(negedge clk); bus_off = 1;
        bits(11 * 50, 1);
        probe(); chk("R11 fifty runs", recov_cnt, 50);
        wr_req(1);
        @(negedge clk); probe(); chk("R2 asleep in bus-off", sleep_ack, 1);
        bits(11 * 20, 1);
        probe(); chk("R11 frozen asleep", recov_cnt, 50);
        wr_req(0);
        probe(); chk("R4 awake", sleep_ack, 0);
        bits(11 * 78, 1);
        probe();
        chk("R11 full count", recov_cnt, 128);
        chk("R11 done", recov_done, 1);
        @(negedge clk); bus_off = 0;
        @(negedge clk); probe(); chk("R11 cleared", recov_cnt, 0);

        repeat (4) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule